// File: doc/BRIEF.md
# One-Time-Programmable Security Register Bank

This block holds seventeen 128-bit one-time-programmable registers and the two lock words that guard them. Each register is reached 16 bits at a time through a single request port that carries an operation code, a 9-bit word offset and a data word. Storage is kept in flip-flops inside the block. Programming can only clear bits: the new word is ANDed into the stored word, so a bit that has gone to 0 stays at 0. Register 0 is split into two halves. The lower half carries a factory identifier that is fixed by a parameter and is locked from reset. The upper half is free for the user.

A two-state sequencer serves one request at a time. In `ST_IDLE` it latches a valid request and moves to `ST_EXEC`. `ST_EXEC` always returns to `ST_IDLE` after one cycle. In that cycle the offset is decoded, the guarding lock bit is looked up, and the block does one of three things: it commits a write, returns read data, or raises the sticky error flags. The program-error flag is raised for a request aimed outside the space its operation may touch. The lock-error flag is raised, together with the program-error flag, for a write to a locked region. Both flags stay set until `clr_status` is pulsed.

Top module: `otp_guard`

## Requirements
- R1: After reset, busy, done, err_prog and err_lock are 0. The factory identifier words read back at offsets 0x81 (bits 15:0) to 0x84 (bits 63:48). Every user word reads 0xFFFF. Lock word 0 at offset 0x80 reads 0xFFFE, and lock word 1 at offset 0x89 reads 0xFFFF.
- R2: A request on req_valid is taken only while busy is 0. busy is 1 for exactly one cycle. done pulses on the next cycle, with rd_data and the flags already updated. A request presented while busy is 1 is ignored.
- R3: Operation code 1 (program word) ANDs req_wdata into the addressed word. Repeated programming of an unlocked word keeps clearing bits and never sets them.
- R4: Register n (1 to 16) occupies the eight offsets from 0x8A+8*(n-1). Register 0 occupies offsets 0x81 to 0x88. A write changes only the addressed word.
- R5: A program-word request whose offset is not in 0x81..0x88 or 0x8A..0x109 (this includes the lock offsets 0x80 and 0x89) sets err_prog only and changes no data.
- R6: A program-word request to a locked region sets err_prog and err_lock and leaves the data unchanged. Offsets 0x81..0x84 are guarded by lock-0 bit 0, which is 0 from reset.
- R7: Operation code 2 (program lock) ANDs req_wdata into lock word 0 (offset 0x80) or lock word 1 (offset 0x89). Lock-0 bit 1 guards offsets 0x85..0x88, and lock-1 bit n-1 guards register n. A lock request to any other offset sets err_prog only.
- R8: A lock bit at 0 never returns to 1, whatever data is later programmed into it.
- R9: err_prog and err_lock stay set across later successful requests until clr_status is pulsed while the block is idle. The pulse clears both.
- R10: Operation code 0 (read) of an offset outside 0x80..0x109 returns 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 program word, 2 program lock, 3 no operation |
| req_addr | input | 9 | Word offset |
| req_wdata | input | 16 | Data ANDed in by program operations |
| clr_status | input | 1 | Clears both error flags |
| busy | output | 1 | Request being executed |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data of the last read |
| err_prog | output | 1 | Sticky program-error flag |
| err_lock | output | 1 | Sticky lock-error flag |

## Verification
A request sampled at one rising edge shows busy after that edge. done, rd_data and both flags change at the following rising edge, and a stored write is visible to a read issued after done. The bench drives inputs and samples outputs at falling edges. It checks busy one falling edge after the request and all results one falling edge later. A clear pulse is checked one edge after it is sampled. For the ignored-request case, the request is held into the busy cycle and the untouched word is then read back.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_PROG = 2'd1,
        OP_LOCK = 2'd2,
        OP_NOP  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_LOCK0,
        TGT_LOCK1,
        TGT_DATA
    } tgt_e;

    typedef enum logic {
        ST_IDLE,
        ST_EXEC
    } state_e;
endpackage

// File: rtl/otp_decode.sv
module otp_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int BASE   = 128,
    parameter int WPR    = 8,
    parameter int N_USER = 16,
    parameter int IDX_W  = 8,
    parameter int GRD_W  = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt,
    output logic [IDX_W-1:0]  idx,
    output logic [GRD_W-1:0]  guard
);
    localparam int REG0_LO  = BASE + 1;
    localparam int LOCK1_A  = REG0_LO + WPR;
    localparam int USER_LO  = LOCK1_A + 1;
    localparam int USER_HI  = USER_LO + N_USER * WPR - 1;

    always_comb begin
        int a;
        a     = int'(addr);
        tgt   = TGT_NONE;
        idx   = '0;
        guard = '0;
        if (a == BASE) begin
            tgt = TGT_LOCK0;
        end else if (a == LOCK1_A) begin
            tgt = TGT_LOCK1;
        end else if (a >= REG0_LO && a < LOCK1_A) begin
            tgt   = TGT_DATA;
            idx   = IDX_W'(a - REG0_LO);
            guard = ((a - REG0_LO) < WPR / 2) ? GRD_W'(0) : GRD_W'(1);
        end else if (a >= USER_LO && a <= USER_HI) begin
            tgt   = TGT_DATA;
            idx   = IDX_W'(WPR + a - USER_LO);
            guard = GRD_W'(2 + (a - USER_LO) / WPR);
        end
    end
endmodule

// File: rtl/otp_store.sv
module otp_store #(
    parameter int                         WORD_W     = 16,
    parameter int                         N_WORDS    = 136,
    parameter int                         IDX_W      = 8,
    parameter int                         FACT_WORDS = 4,
    parameter logic [FACT_WORDS*WORD_W-1:0] FACTORY_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              lk0_en,
    input  logic              lk1_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] lock0_q,
    output logic [WORD_W-1:0] lock1_q
);
    logic [WORD_W-1:0] words [N_WORDS];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] q;
        logic              hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));
        if (g < FACT_WORDS) begin : g_fact
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= FACTORY_ID[g*WORD_W +: WORD_W];
                else if (hit) q <= q & wr_data;
            end
        end else begin : g_user
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   q <= '1;
                else if (hit) q <= q & wr_data;
            end
        end
        assign words[g] = q;
    end

    assign rd_word = words[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock0_q <= {{(WORD_W-1){1'b1}}, 1'b0};
            lock1_q <= '1;
        end else begin
            if (lk0_en) lock0_q <= lock0_q & wr_data;
            if (lk1_en) lock1_q <= lock1_q & wr_data;
        end
    end
endmodule

// File: rtl/otp_guard.sv
module otp_guard
    import otp_pkg::*;
#(
    parameter int          WORD_W     = 16,
    parameter int          ADDR_W     = 9,
    parameter int          N_USER     = 16,
    parameter int          WPR        = 8,
    parameter int          BASE       = 128,
    parameter logic [63:0] FACTORY_ID = 64'h0123_4567_89AB_CDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic              clr_status,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rd_data,
    output logic              err_prog,
    output logic              err_lock
);
    localparam int N_WORDS    = (N_USER + 1) * WPR;
    localparam int IDX_W      = $clog2(N_WORDS);
    localparam int GRD_W      = $clog2(N_USER + 2);
    localparam int FACT_WORDS = WPR / 2;

    state_e            state_q, state_d;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;

    tgt_e              tgt;
    logic [IDX_W-1:0]  idx;
    logic [GRD_W-1:0]  guard;
    logic [WORD_W-1:0] rd_word, lock0_q, lock1_q;
    logic [N_USER+1:0] lockvec;
    logic              exec, locked, wr_en, lk0_en, lk1_en;
    logic              set_perr, set_lerr;
    logic [WORD_W-1:0] rd_next;

    otp_decode #(
        .ADDR_W(ADDR_W), .BASE(BASE), .WPR(WPR), .N_USER(N_USER),
        .IDX_W(IDX_W), .GRD_W(GRD_W)
    ) i_decode (
        .addr(addr_q), .tgt(tgt), .idx(idx), .guard(guard)
    );

    otp_store #(
        .WORD_W(WORD_W), .N_WORDS(N_WORDS), .IDX_W(IDX_W),
        .FACT_WORDS(FACT_WORDS),
        .FACTORY_ID(FACTORY_ID[FACT_WORDS*WORD_W-1:0])
    ) i_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(idx), .wr_data(wdata_q),
        .lk0_en(lk0_en), .lk1_en(lk1_en),
        .rd_idx(idx), .rd_word(rd_word),
        .lock0_q(lock0_q), .lock1_q(lock1_q)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request latch, loaded only when a request is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_NOP;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            op_q    <= op_e'(req_op);
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign exec    = (state_q == ST_EXEC);
    assign busy    = exec;
    assign lockvec = {lock1_q[N_USER-1:0], lock0_q[1:0]};
    assign locked  = ~lockvec[guard];
    assign wr_en   = exec && op_q == OP_PROG && tgt == TGT_DATA && !locked;
    assign lk0_en  = exec && op_q == OP_LOCK && tgt == TGT_LOCK0;
    assign lk1_en  = exec && op_q == OP_LOCK && tgt == TGT_LOCK1;

    // Result of the executing request
    always_comb begin
        set_perr = 1'b0;
        set_lerr = 1'b0;
        rd_next  = rd_data;
        if (exec) begin
            unique case (op_q)
                OP_READ: begin
                    unique case (tgt)
                        TGT_DATA:  rd_next = rd_word;
                        TGT_LOCK0: rd_next = lock0_q;
                        TGT_LOCK1: rd_next = lock1_q;
                        TGT_NONE:  rd_next = '1;
                    endcase
                end
                OP_PROG: begin
                    if (tgt != TGT_DATA) begin
                        set_perr = 1'b1;
                    end else if (locked) begin
                        set_perr = 1'b1;
                        set_lerr = 1'b1;
                    end
                end
                OP_LOCK: set_perr = !(tgt == TGT_LOCK0 || tgt == TGT_LOCK1);
                OP_NOP:  ;
            endcase
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            rd_data  <= '1;
            err_prog <= 1'b0;
            err_lock <= 1'b0;
        end else begin
            done     <= exec;
            rd_data  <= rd_next;
            err_prog <= (err_prog & ~clr_status) | set_perr;
            err_lock <= (err_lock & ~clr_status) | set_lerr;
        end
    end
endmodule

// File: rtl/otp_guard_chk.sv
module otp_guard_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              clr_status,
    input logic              busy,
    input logic              done,
    input logic              err_prog,
    input logic              err_lock,
    input logic [WORD_W-1:0] lock0_q,
    input logic [WORD_W-1:0] lock1_q
);
    // R2
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);
    // R2
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    // R6
    factory_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock0_q[0] == 1'b0);
    // R6
    lock_err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_lock |-> err_prog);
    // R8
    lock0_irrev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(lock0_q)) & lock0_q) == '0);
    // R8
    lock1_irrev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~$past(lock1_q)) & lock1_q) == '0);
    // R9
    sticky_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_prog && !clr_status) |=> err_prog);
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !busy) |=> (!err_prog && !err_lock));
endmodule

bind otp_guard otp_guard_chk #(.WORD_W(WORD_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .clr_status(clr_status),
    .busy(busy), .done(done), .err_prog(err_prog), .err_lock(err_lock),
    .lock0_q(lock0_q), .lock1_q(lock1_q)
);

// File: tb/test_otp_guard.sv
`timescale 1ns/1ps
module test_otp_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [8:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        clr_status = 1'b0;
    logic        busy, done, err_prog, err_lock;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    otp_guard #(.FACTORY_ID(64'h0123_4567_89AB_CDEF)) i_otp_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .clr_status(clr_status),
        .busy(busy), .done(done), .rd_data(rd_data),
        .err_prog(err_prog), .err_lock(err_lock)
    );

    typedef struct packed {
        logic [3:0]  tag;
        logic [1:0]  op;
        logic [8:0]  addr;
        logic [15:0] wd;
        logic [15:0] exp;
        logic        pe;
        logic        le;
    } vec_t;

    localparam int NV = 33;
    // op: 0 read, 1 program word, 2 program lock
    localparam vec_t TBL [NV] = '{
        '{4'd1,  2'd0, 9'h081, 16'h0000, 16'hCDEF, 1'b0, 1'b0}, // R1
        '{4'd1,  2'd0, 9'h084, 16'h0000, 16'h0123, 1'b0, 1'b0}, // R1
        '{4'd1,  2'd0, 9'h085, 16'h0000, 16'hFFFF, 1'b0, 1'b0}, // R1
        '{4'd1,  2'd0, 9'h080, 16'h0000, 16'hFFFE, 1'b0, 1'b0}, // R1
        '{4'd1,  2'd0, 9'h089, 16'h0000, 16'hFFFF, 1'b0, 1'b0}, // R1
        '{4'd3,  2'd1, 9'h085, 16'hF0F0, 16'h0000, 1'b0, 1'b0}, // R3
        '{4'd3,  2'd0, 9'h085, 16'h0000, 16'hF0F0, 1'b0, 1'b0}, // R3
        '{4'd3,  2'd1, 9'h085, 16'h0FFF, 16'h0000, 1'b0, 1'b0}, // R3
        '{4'd3,  2'd0, 9'h085, 16'h0000, 16'h00F0, 1'b0, 1'b0}, // R3
        '{4'd3,  2'd1, 9'h085, 16'hFFFF, 16'h0000, 1'b0, 1'b0}, // R3
        '{4'd3,  2'd0, 9'h085, 16'h0000, 16'h00F0, 1'b0, 1'b0}, // R3
        '{4'd6,  2'd1, 9'h082, 16'h0000, 16'h0000, 1'b1, 1'b1}, // R6
        '{4'd6,  2'd0, 9'h082, 16'h0000, 16'h89AB, 1'b0, 1'b0}, // R6
        '{4'd5,  2'd1, 9'h080, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R5
        '{4'd5,  2'd1, 9'h10A, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R5
        '{4'd5,  2'd0, 9'h080, 16'h0000, 16'hFFFE, 1'b0, 1'b0}, // R5
        '{4'd10, 2'd0, 9'h10A, 16'h0000, 16'hFFFF, 1'b0, 1'b0}, // R10
        '{4'd10, 2'd0, 9'h07F, 16'h0000, 16'hFFFF, 1'b0, 1'b0}, // R10
        '{4'd4,  2'd1, 9'h093, 16'h1234, 16'h0000, 1'b0, 1'b0}, // R4
        '{4'd4,  2'd0, 9'h093, 16'h0000, 16'h1234, 1'b0, 1'b0}, // R4
        '{4'd4,  2'd0, 9'h092, 16'h0000, 16'hFFFF, 1'b0, 1'b0}, // R4
        '{4'd4,  2'd1, 9'h109, 16'hAAAA, 16'h0000, 1'b0, 1'b0}, // R4
        '{4'd4,  2'd0, 9'h109, 16'h0000, 16'hAAAA, 1'b0, 1'b0}, // R4
        '{4'd7,  2'd2, 9'h089, 16'hFFFD, 16'h0000, 1'b0, 1'b0}, // R7
        '{4'd7,  2'd0, 9'h089, 16'h0000, 16'hFFFD, 1'b0, 1'b0}, // R7
        '{4'd6,  2'd1, 9'h093, 16'h0000, 16'h0000, 1'b1, 1'b1}, // R6
        '{4'd6,  2'd0, 9'h093, 16'h0000, 16'h1234, 1'b0, 1'b0}, // R6
        '{4'd7,  2'd1, 9'h08A, 16'h5555, 16'h0000, 1'b0, 1'b0}, // R7
        '{4'd8,  2'd2, 9'h089, 16'hFFFF, 16'h0000, 1'b0, 1'b0}, // R8
        '{4'd8,  2'd0, 9'h089, 16'h0000, 16'hFFFD, 1'b0, 1'b0}, // R8
        '{4'd7,  2'd2, 9'h085, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R7
        '{4'd7,  2'd2, 9'h080, 16'hFFFD, 16'h0000, 1'b0, 1'b0}, // R7
        '{4'd7,  2'd1, 9'h086, 16'h0000, 16'h0000, 1'b1, 1'b1}  // R7
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request; returns at the falling edge where results are due.
    task automatic issue(input logic [1:0] op, input logic [8:0] addr, input logic [15:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 busy", {15'd0, busy}, 16'd1);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_status();
        @(negedge clk);
        clr_status = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_status = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {15'd0, busy}, 16'd0);
        chk("R1 done", {15'd0, done}, 16'd0);
        chk("R1 err_prog", {15'd0, err_prog}, 16'd0);
        chk("R1 err_lock", {15'd0, err_lock}, 16'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", TBL[i].tag, i);
            issue(TBL[i].op, TBL[i].addr, TBL[i].wd);
            chk({tg, " done"}, {15'd0, done}, 16'd1);
            if (TBL[i].op == 2'd0) chk({tg, " rd_data"}, rd_data, TBL[i].exp);
            chk({tg, " err_prog"}, {15'd0, err_prog}, {15'd0, TBL[i].pe});
            chk({tg, " err_lock"}, {15'd0, err_lock}, {15'd0, TBL[i].le});
            clear_status();
        end

        // R7 earlier user-half lock left data intact
        issue(2'd0, 9'h085, 16'h0000);
        chk("R7 user half data", rd_data, 16'h00F0);
        issue(2'd0, 9'h080, 16'h0000);
        chk("R7 lock0 value", rd_data, 16'hFFFC);

        // R2 request held into the busy cycle is ignored
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_addr = 9'h09A; req_wdata = 16'h0F0F;
        @(posedge clk);
        @(negedge clk);
        req_wdata = 16'h0000;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 done pulse", {15'd0, done}, 16'd1);
        chk("R2 not busy", {15'd0, busy}, 16'd0);
        issue(2'd0, 9'h09A, 16'h0000);
        chk("R2 ignored write", rd_data, 16'h0F0F);

        // R9 sticky flags and clear
        issue(2'd1, 9'h083, 16'h0000);
        issue(2'd0, 9'h081, 16'h0000);
        chk("R9 err_prog sticky", {15'd0, err_prog}, 16'd1);
        chk("R9 err_lock sticky", {15'd0, err_lock}, 16'd1);
        chk("R9 read during error", rd_data, 16'hCDEF);
        clear_status();
        chk("R9 err_prog cleared", {15'd0, err_prog}, 16'd0);
        chk("R9 err_lock cleared", {15'd0, err_lock}, 16'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule